// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block stores 64 single-precision registers as raw 32-bit patterns and exposes them to an execution pipeline through a set of addressing views. A 32-bit control word holds three mode bits: bank select, transfer size and precision. The bank bit picks which group of sixteen registers a bank-relative index reaches. The size bit changes the meaning of the move view. The precision bit is held for the consuming datapath. The block converts nothing and does no arithmetic: a double is only the concatenation of two neighbouring 32-bit registers.

One write port and one read port each carry a view code and an index. Writes take effect at the rising clock edge. Reads are combinational and return the contents from before any write in the same cycle. A double view given an odd base index is illegal. So is an unknown view code. In either case the port raises its error output, a read returns zero and a write is dropped. The control word can be loaded whole, or one mode bit can be changed at a time.

Top module: `fpbank_regfile`

## Requirements
- R1: After reset the control word `ctl_q` is zero. The bank bit sits at bit 21, the size bit at bit 20 and the precision bit at bit 19.
- R2: View code 0 (current single) at index n reads and writes physical register 16*B+n. B is the bank bit and n is `idx[3:0]`. The read returns the word in `rd_data[31:0]` with the upper half zero. A write stores `wr_data[31:0]`.
- R3: View code 1 (other single) at index n reaches physical register 16*(1-B)+n.
- R4: View code 2 (pair) at even index i treats register i as bits 63:32 and register i+1 as bits 31:0 of a 64-bit value. A write splits the value the same way.
- R5: View code 3 (current double) at even n is the pair at 16*B+n. View code 4 (other double) at even n is the pair at 16*(1-B)+n.
- R6: View code 5 (move) with the size bit set reaches the current double at 16*B+n for even n. For odd n it reaches the other-bank pair at 16*(1-B)+(n with bit 0 cleared).
- R7: View code 5 with the size bit clear is a current-bank single access at 16*B+n.
- R8: A single-bit control write changes only the chosen bit. Selector 0 picks the bank bit, 1 the size bit and 2 the precision bit. Selector 3 changes nothing. With no control write the word holds its value.
- R9: A full control write loads all 32 bits from `ctl_wdata` at the next edge and takes precedence over a single-bit write in the same cycle.
- R10: A read of the register being written in the same cycle returns the old contents. The new value is visible from the next cycle.
- R11: A pair, current-double, other-double or sized-move access with an even index is legal. Codes 2, 3 and 4 with an odd index (bit 0 of the index) are illegal. An illegal access raises the port's error output. An illegal read returns zero. An illegal write leaves every register unchanged.
- R12: View codes 6 and 7 are illegal with the same effects as R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the control word |
| ctl_we | input | 1 | Full control word write |
| ctl_wdata | input | 32 | Value for a full control write |
| bit_we | input | 1 | Single mode-bit write |
| bit_sel | input | 2 | Mode bit selector: 0 bank, 1 size, 2 precision, 3 none |
| bit_val | input | 1 | New value for the selected mode bit |
| ctl_q | output | 32 | Current control word |
| wr_en | input | 1 | Register write enable |
| wr_view | input | 3 | View code for the write |
| wr_idx | input | 6 | Index for the write |
| wr_data | input | 64 | Write data; singles use bits 31:0 |
| wr_err | output | 1 | Write access is illegal |
| rd_view | input | 3 | View code for the read |
| rd_idx | input | 6 | Index for the read |
| rd_data | output | 64 | Read data, combinational |
| rd_err | output | 1 | Read access is illegal |

## Verification
The bench builds the block with its default parameters: 64 registers in banks of sixteen, with the mode bits at 21, 20 and 19. With these values the pair view reaches all 64 registers, while the bank views reach only the lower 32. A single random run therefore covers every bank-relative mapping in both banks. It also covers the upper registers that only the pair view can reach. Random full control writes flip the bank and size bits often, so move accesses fall in both size modes with both index parities.

// File: rtl/fpbank_pkg.sv
`timescale 1ns/1ps
package fpbank_pkg;
    typedef enum logic [2:0] {
        VW_SCUR = 3'd0,
        VW_SOTH = 3'd1,
        VW_PAIR = 3'd2,
        VW_DCUR = 3'd3,
        VW_DOTH = 3'd4,
        VW_MOVE = 3'd5
    } view_e;

    typedef enum logic [1:0] {
        MB_BANK = 2'd0,
        MB_SIZE = 2'd1,
        MB_PREC = 2'd2,
        MB_NONE = 2'd3
    } mode_bit_e;
endpackage

// File: rtl/fpbank_addr_map.sv
`timescale 1ns/1ps
module fpbank_addr_map #(
    parameter int NREG = 64,
    parameter int BANK = 16
) (
    input  logic [2:0]                view,
    input  logic [$clog2(NREG)-1:0]   idx,
    input  logic                      bank_sel,
    input  logic                      size_sel,
    output logic [$clog2(NREG)-1:0]   phys,
    output logic                      dbl,
    output logic                      err
);
    import fpbank_pkg::*;
    localparam int IW = $clog2(NREG);
    localparam int BW = $clog2(BANK);

    logic [BW-1:0] n;
    logic [IW-1:0] cur_base;
    logic [IW-1:0] oth_base;
    logic [IW-1:0] cur_phys;
    logic [IW-1:0] oth_phys;

    always_comb begin
        n        = idx[BW-1:0];
        cur_base = bank_sel ? IW'(BANK) : '0;
        oth_base = bank_sel ? '0 : IW'(BANK);
        cur_phys = cur_base + IW'(n);
        oth_phys = oth_base + IW'(n);
    end

    always_comb begin
        phys = cur_phys;
        dbl  = 1'b0;
        err  = 1'b0;
        case (view)
            VW_SCUR: phys = cur_phys;
            VW_SOTH: phys = oth_phys;
            VW_PAIR: begin
                phys = idx;
                dbl  = 1'b1;
                err  = idx[0];
            end
            VW_DCUR: begin
                phys = cur_phys;
                dbl  = 1'b1;
                err  = n[0];
            end
            VW_DOTH: begin
                phys = oth_phys;
                dbl  = 1'b1;
                err  = n[0];
            end
            VW_MOVE: begin
                if (size_sel) begin
                    dbl  = 1'b1;
                    phys = n[0] ? {oth_phys[IW-1:1], 1'b0} : cur_phys;
                end else begin
                    phys = cur_phys;
                end
            end
            default: err = 1'b1;
        endcase
    end
endmodule

// File: rtl/fpbank_store.sv
`timescale 1ns/1ps
module fpbank_store #(
    parameter int NREG = 64,
    parameter int WW   = 32
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic                      wdbl,
    input  logic [$clog2(NREG)-1:0]   wphys,
    input  logic [2*WW-1:0]           wdata,
    input  logic                      rdbl,
    input  logic                      rerr,
    input  logic [$clog2(NREG)-1:0]   rphys,
    output logic [2*WW-1:0]           rdata
);
    localparam int IW = $clog2(NREG);

    logic [WW-1:0] mem [NREG];
    logic [IW-1:0] wmate;
    logic [IW-1:0] rmate;

    assign wmate = wphys | IW'(1);
    assign rmate = rphys | IW'(1);

    always_ff @(posedge clk) begin
        if (we) begin
            if (wdbl) begin
                mem[wphys] <= wdata[2*WW-1:WW];
                mem[wmate] <= wdata[WW-1:0];
            end else begin
                mem[wphys] <= wdata[WW-1:0];
            end
        end
    end

    always_comb begin
        if (rerr)
            rdata = '0;
        else if (rdbl)
            rdata = {mem[rphys], mem[rmate]};
        else
            rdata = {{WW{1'b0}}, mem[rphys]};
    end
endmodule

// File: rtl/fpbank_ctl.sv
`timescale 1ns/1ps
module fpbank_ctl #(
    parameter int CW       = 32,
    parameter int BANK_POS = 21,
    parameter int SIZE_POS = 20,
    parameter int PREC_POS = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          full_we,
    input  logic [CW-1:0] full_d,
    input  logic          bit_we,
    input  logic [1:0]    bit_sel,
    input  logic          bit_val,
    output logic [CW-1:0] ctl_q
);
    import fpbank_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (full_we) begin
            ctl_q <= full_d;
        end else if (bit_we) begin
            case (bit_sel)
                MB_BANK: ctl_q[BANK_POS] <= bit_val;
                MB_SIZE: ctl_q[SIZE_POS] <= bit_val;
                MB_PREC: ctl_q[PREC_POS] <= bit_val;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fpbank_regfile.sv
`timescale 1ns/1ps
module fpbank_regfile #(
    parameter int NREG     = 64,
    parameter int BANK     = 16,
    parameter int WW       = 32,
    parameter int CW       = 32,
    parameter int BANK_POS = 21,
    parameter int SIZE_POS = 20,
    parameter int PREC_POS = 19
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ctl_we,
    input  logic [CW-1:0]           ctl_wdata,
    input  logic                    bit_we,
    input  logic [1:0]              bit_sel,
    input  logic                    bit_val,
    output logic [CW-1:0]           ctl_q,
    input  logic                    wr_en,
    input  logic [2:0]              wr_view,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [2*WW-1:0]         wr_data,
    output logic                    wr_err,
    input  logic [2:0]              rd_view,
    input  logic [$clog2(NREG)-1:0] rd_idx,
    output logic [2*WW-1:0]         rd_data,
    output logic                    rd_err
);
    localparam int IW = $clog2(NREG);

    logic [IW-1:0] w_phys;
    logic [IW-1:0] r_phys;
    logic          w_dbl;
    logic          r_dbl;

    fpbank_ctl #(
        .CW(CW), .BANK_POS(BANK_POS), .SIZE_POS(SIZE_POS), .PREC_POS(PREC_POS)
    ) ctl_i (
        .clk(clk), .rst(rst), .full_we(ctl_we), .full_d(ctl_wdata),
        .bit_we(bit_we), .bit_sel(bit_sel), .bit_val(bit_val), .ctl_q(ctl_q)
    );

    fpbank_addr_map #(.NREG(NREG), .BANK(BANK)) wmap_i (
        .view(wr_view), .idx(wr_idx),
        .bank_sel(ctl_q[BANK_POS]), .size_sel(ctl_q[SIZE_POS]),
        .phys(w_phys), .dbl(w_dbl), .err(wr_err)
    );

    fpbank_addr_map #(.NREG(NREG), .BANK(BANK)) rmap_i (
        .view(rd_view), .idx(rd_idx),
        .bank_sel(ctl_q[BANK_POS]), .size_sel(ctl_q[SIZE_POS]),
        .phys(r_phys), .dbl(r_dbl), .err(rd_err)
    );

    fpbank_store #(.NREG(NREG), .WW(WW)) store_i (
        .clk(clk), .we(wr_en && !wr_err), .wdbl(w_dbl), .wphys(w_phys),
        .wdata(wr_data), .rdbl(r_dbl), .rerr(rd_err), .rphys(r_phys),
        .rdata(rd_data)
    );
endmodule

// File: rtl/fpbank_checker.sv
`timescale 1ns/1ps
module fpbank_checker #(
    parameter int NREG = 64,
    parameter int WW   = 32,
    parameter int CW   = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ctl_we,
    input logic [CW-1:0]           ctl_wdata,
    input logic                    bit_we,
    input logic [CW-1:0]           ctl_q,
    input logic                    wr_en,
    input logic [2:0]              wr_view,
    input logic [$clog2(NREG)-1:0] wr_idx,
    input logic [2*WW-1:0]         wr_data,
    input logic                    wr_err,
    input logic [2:0]              rd_view,
    input logic [$clog2(NREG)-1:0] rd_idx,
    input logic [2*WW-1:0]         rd_data,
    input logic                    rd_err
);
    import fpbank_pkg::*;

    assert_one_bit_R8: assert property (@(posedge clk) disable iff (rst)
        (bit_we && !ctl_we) |=> ($countones(ctl_q ^ $past(ctl_q)) <= 1));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!bit_we && !ctl_we) |=> $stable(ctl_q));

    assert_full_load_R9: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ctl_q == $past(ctl_wdata)));

    assert_odd_pair_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_view == 3'(VW_PAIR) && rd_idx[0]) |-> rd_err);

    assert_err_zero_R11: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_data == '0));

    assert_bad_view_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_view > 3'(VW_MOVE)) |-> (rd_err && !rd_dbl_dummy()));

    function automatic logic rd_dbl_dummy();
        return 1'b0;
    endfunction

    assert_new_next_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_err && wr_view == 3'(VW_SCUR) && rd_view == 3'(VW_SCUR)
         && rd_idx[3:0] == wr_idx[3:0] && !ctl_we && !bit_we)
        |=> (!($stable(rd_view) && $stable(rd_idx))
             || rd_data[WW-1:0] == $past(wr_data[WW-1:0])));
endmodule

bind fpbank_regfile fpbank_checker #(.NREG(NREG), .WW(WW), .CW(CW)) chk_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .bit_we(bit_we), .ctl_q(ctl_q), .wr_en(wr_en), .wr_view(wr_view),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err),
    .rd_view(rd_view), .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err)
);

// File: tb/fpbank_regfile_tb_top.sv
`timescale 1ns/1ps
module fpbank_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        bit_we = 1'b0;
    logic [1:0]  bit_sel = '0;
    logic        bit_val = 1'b0;
    logic [31:0] ctl_q;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_view = '0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        wr_err;
    logic [2:0]  rd_view = '0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        rd_err;

    int checks = 0;
    int errors = 0;
    logic [31:0] mm [64];
    logic [31:0] mc = '0;
    bit done = 0;

    always #5 clk = ~clk;

    fpbank_regfile dut_i (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .bit_we(bit_we), .bit_sel(bit_sel), .bit_val(bit_val), .ctl_q(ctl_q),
        .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_err(wr_err), .rd_view(rd_view), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_err(rd_err)
    );

    // returns {err, dbl, phys[5:0]}
    function automatic logic [7:0] emap(logic [2:0] v, logic [5:0] i, logic [31:0] c);
        int b = c[21];
        int s = c[20];
        int n = i[3:0];
        int p = 0;
        logic d = 0;
        logic e = 0;
        case (v)
            3'd0: p = 16*b + n;
            3'd1: p = 16*(1-b) + n;
            3'd2: begin p = i; d = 1; e = i[0]; end
            3'd3: begin p = 16*b + n; d = 1; e = i[0]; end
            3'd4: begin p = 16*(1-b) + n; d = 1; e = i[0]; end
            3'd5: begin
                if (s == 1) begin
                    d = 1;
                    p = (n % 2 == 1) ? 16*(1-b) + (n - 1) : 16*b + n;
                end else p = 16*b + n;
            end
            default: e = 1;
        endcase
        return {e, d, 6'(p)};
    endfunction

    function automatic logic [63:0] eread(logic [7:0] m);
        if (m[7]) return 64'd0;
        if (m[6]) return {mm[m[5:0]], mm[m[5:0] + 6'd1]};
        return {32'd0, mm[m[5:0]]};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic cw, logic [31:0] cd, logic bw,
                        logic [1:0] bs, logic bv, logic we, logic [2:0] wv,
                        logic [5:0] wi, logic [63:0] wd, logic [2:0] rv,
                        logic [5:0] ri);
        logic [7:0] wm;
        logic [7:0] rm;
        @(negedge clk);
        ctl_we = cw; ctl_wdata = cd; bit_we = bw; bit_sel = bs; bit_val = bv;
        wr_en = we; wr_view = wv; wr_idx = wi; wr_data = wd;
        rd_view = rv; rd_idx = ri;
        #1;
        wm = emap(wv, wi, mc);
        rm = emap(rv, ri, mc);
        chk(tag, ctl_q, mc);
        chk(tag, rd_data, eread(rm));
        chk(tag, {63'd0, rd_err}, {63'd0, rm[7]});
        chk(tag, {63'd0, wr_err}, {63'd0, wm[7]});
        @(posedge clk);
        if (we && !wm[7]) begin
            if (wm[6]) begin
                mm[wm[5:0]] = wd[63:32];
                mm[wm[5:0] + 6'd1] = wd[31:0];
            end else mm[wm[5:0]] = wd[31:0];
        end
        if (cw) mc = cd;
        else if (bw) begin
            case (bs)
                2'd0: mc[21] = bv;
                2'd1: mc[20] = bv;
                2'd2: mc[19] = bv;
                default: ;
            endcase
        end
    endtask

    task automatic rd(string tag, logic [2:0] v, logic [5:0] i);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, v, i);
    endtask

    task automatic setbit(string tag, logic [1:0] s, logic v);
        step(tag, 0, 0, 1, s, v, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset value
        #1 chk("R1", {32'd0, ctl_q}, 64'd0);
        // R4: fill all registers through the pair view
        for (int k = 0; k < 32; k++)
            step("R4", 0, 0, 0, 0, 0, 1, 3'd2, 6'(2*k),
                 {32'hA000_0000 | 32'(2*k), 32'hA000_0000 | 32'(2*k+1)}, 3'd2, 6'(2*k));
        rd("R4", 3'd2, 6'd62);
        rd("R2", 3'd0, 6'd3);
        rd("R3", 3'd1, 6'd3);
        rd("R5", 3'd3, 6'd2);
        rd("R5", 3'd4, 6'd6);
        setbit("R8", 2'd0, 1'b1);
        rd("R8", 3'd0, 6'd0);
        rd("R2", 3'd0, 6'd7);
        rd("R3", 3'd1, 6'd7);
        rd("R5", 3'd3, 6'd4);
        rd("R5", 3'd4, 6'd4);
        setbit("R8", 2'd3, 1'b1);
        setbit("R8", 2'd1, 1'b1);
        rd("R6", 3'd5, 6'd8);
        rd("R6", 3'd5, 6'd9);
        setbit("R8", 2'd1, 1'b0);
        rd("R7", 3'd5, 6'd9);
        setbit("R8", 2'd2, 1'b1);
        // R10: same-cycle write and read of one register
        step("R10", 0, 0, 0, 0, 0, 1, 3'd0, 6'd5, 64'h1234_5678, 3'd0, 6'd5);
        rd("R10", 3'd0, 6'd5);
        // R11: illegal double write leaves the store unchanged
        step("R11", 0, 0, 0, 0, 0, 1, 3'd3, 6'd3, 64'hDEAD_BEEF_0BAD_F00D, 3'd3, 6'd3);
        rd("R11", 3'd2, 6'd18);
        rd("R11", 3'd2, 6'd20);
        rd("R11", 3'd2, 6'd63);
        // R12: unknown view codes
        rd("R12", 3'd6, 6'd0);
        step("R12", 0, 0, 0, 0, 0, 1, 3'd7, 6'd4, 64'hFFFF_FFFF_FFFF_FFFF, 3'd7, 6'd2);
        rd("R12", 3'd2, 6'd4);
        // R9: full write wins over a bit write
        step("R9", 1, 32'h0010_0000, 1, 2'd0, 1'b1, 0, 0, 0, 0, 0, 0);
        rd("R9", 3'd5, 6'd3);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] rv = 3'($urandom_range(0, 7));
            string tg;
            case (rv)
                3'd0: tg = "R2";
                3'd1: tg = "R3";
                3'd2: tg = "R4";
                3'd3, 3'd4: tg = "R5";
                3'd5: tg = mc[20] ? "R6" : "R7";
                default: tg = "R12";
            endcase
            step(tg, ($urandom_range(0, 15) == 0), $urandom,
                 ($urandom_range(0, 7) == 0), 2'($urandom_range(0, 3)),
                 1'($urandom), 1'($urandom), 3'($urandom_range(0, 7)),
                 6'($urandom), {$urandom, $urandom}, rv, 6'($urandom));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial void'($urandom(32'd2024));
endmodule